// File: doc/BRIEF.md
# Host Port Address Pointer Unit

This block keeps the two address pointers behind a simple host-to-processor port. One pointer addresses reads from internal resources, and the other addresses writes to them. On the internal side these roles are fixed. Each host cycle carries a 2-bit control code, a direction line and a write-data word. The block decodes these into four kinds of action: a configuration access, a pointer load or readback, a data cycle with autoincrement, or a plain data cycle.

A configuration bit sets how the host sees the pointers. With the bit clear, the host sees a single address register: a load writes both pointers, and every autoincrement data cycle advances both. With the bit set, the host sees two separate registers. A select input then picks which pointer a load writes, and an autoincrement data cycle advances only the pointer that matches its direction. Every data cycle sends a one-cycle request to the internal side, carrying its direction and the pointer value from before the increment.

Top module: `hostptr_unit`

## Requirements
- R1: After reset, both pointers are zero, the configuration bit is 0 (shared mode), neither request is raised, and the readback word is zero.
- R2: Control code 00 with host_rd low sets the configuration bit from host_wdata[0]. With host_rd high, the cycle after returns the bit on host_rdata[0], with every upper bit zero.
- R3: In shared mode, control code 10 with host_rd low loads host_wdata into both pointers with bits [1:0] forced to zero. host_sel has no effect on this load.
- R4: In split mode, control code 10 with host_rd low loads only one pointer, chosen by host_sel: 0 selects the write pointer and 1 selects the read pointer. Bits [1:0] are forced to zero.
- R5: Control code 10 with host_rd high returns the read pointer on host_rdata in the following cycle, in either mode.
- R6: In shared mode, a data cycle with control code 01 adds 4 to both pointers, whatever its direction.
- R7: In split mode, a code 01 cycle with host_rd high adds 4 to the read pointer only. With host_rd low, it adds 4 to the write pointer only.
- R8: A data cycle with control code 11 leaves both pointers unchanged.
- R9: A data cycle (code 01 or 11) raises rd_req (host_rd high) or wr_req (host_rd low) for exactly the next cycle. req_addr then holds the matching pointer's value from before any increment. Outside data cycles both requests stay low.
- R10: Writing the configuration bit leaves both pointer values unchanged.
- R11: Increments wrap modulo 2^32, so 0xFFFFFFFC steps to 0x00000000. Bits [1:0] of both pointers are always zero.
- R12: With host_cycle low, no pointer, configuration bit or readback word changes, and no request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_cycle | input | 1 | A host cycle is present this clock |
| host_ctl | input | 2 | Control code: 00 config, 01 data+inc, 10 pointer, 11 data |
| host_rd | input | 1 | 1 = host read, 0 = host write |
| host_sel | input | 1 | Split-mode pointer load target: 0 write, 1 read |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Readback of configuration bit or read pointer |
| dual_mode | output | 1 | Configuration bit: 1 = split pointers |
| rd_ptr | output | 32 | Read pointer |
| wr_ptr | output | 32 | Write pointer |
| rd_req | output | 1 | One-cycle internal read request |
| wr_req | output | 1 | One-cycle internal write request |
| req_addr | output | 32 | Address for the raised request |

## Verification
The bench checks that host_sel is ignored in shared mode and honoured in split mode. A design that mixed these up would leave the two pointers different after a shared load, or overwrite both pointers in split mode. It checks the wrap from the top word to zero, where a design with a carry fault would produce an unaligned or nonzero result. It also checks that a request carries the pointer from before the increment, where an off-by-one design would report the address 4 bytes ahead. Random cycles that mix mode changes with loads and data cycles show whether a direction ever advances the wrong pointer, or whether a mode write disturbs the stored values.

// File: rtl/hpu_pkg.sv
package hpu_pkg;
    typedef enum logic [1:0] {
        CTL_CFG      = 2'b00,
        CTL_DATA_INC = 2'b01,
        CTL_PTR      = 2'b10,
        CTL_DATA     = 2'b11
    } ctl_e;

    // pointer slot indices
    localparam int SLOT_WR = 0;
    localparam int SLOT_RD = 1;
    localparam int NSLOT   = 2;
endpackage

// File: rtl/hpu_decode.sv
module hpu_decode
    import hpu_pkg::*;
(
    input  logic             cycle,
    input  logic [1:0]       ctl,
    input  logic             rd,
    input  logic             sel,
    input  logic             dual,
    output logic [NSLOT-1:0] ld,
    output logic [NSLOT-1:0] inc,
    output logic             cfg_wr,
    output logic             cfg_rd,
    output logic             ptr_rd,
    output logic             dreq_rd,
    output logic             dreq_wr
);
    logic ptr_wr, data_any, data_inc;

    always_comb begin
        ptr_wr   = cycle && (ctl == CTL_PTR) && !rd;
        ptr_rd   = cycle && (ctl == CTL_PTR) && rd;
        cfg_wr   = cycle && (ctl == CTL_CFG) && !rd;
        cfg_rd   = cycle && (ctl == CTL_CFG) && rd;
        data_inc = cycle && (ctl == CTL_DATA_INC);
        data_any = cycle && ((ctl == CTL_DATA_INC) || (ctl == CTL_DATA));
        dreq_rd  = data_any && rd;
        dreq_wr  = data_any && !rd;

        ld = '0;
        inc = '0;
        if (dual) begin
            ld[SLOT_RD]  = ptr_wr && sel;
            ld[SLOT_WR]  = ptr_wr && !sel;
            inc[SLOT_RD] = data_inc && rd;
            inc[SLOT_WR] = data_inc && !rd;
        end else begin
            ld  = {NSLOT{ptr_wr}};
            inc = {NSLOT{data_inc}};
        end
    end
endmodule

// File: rtl/hpu_pointer.sv
module hpu_pointer #(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              inc,
    input  logic [ADDR_W-1:0] load_val,
    output logic [ADDR_W-1:0] ptr
);
    localparam int LSB_W = $clog2(WORD_BYTES);
    localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << LSB_W) - 1);
    localparam logic [ADDR_W-1:0] STEP     = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (load)
            ptr_d = load_val & ~LOW_MASK;
        else if (inc)
            ptr_d = ptr_q + STEP;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign ptr = ptr_q;

    // R11: pointer always word aligned
    a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (ptr_q & LOW_MASK) == '0);
    // R6/R7/R11: increment adds one word, modulo width
    a_r11_step: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !load) |=> ptr_q == $past(ptr_q) + STEP);
    // R8/R12: no enable, no change
    a_r12_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc && !load) |=> $stable(ptr_q));
endmodule

// File: rtl/hostptr_unit.sv
module hostptr_unit
    import hpu_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int WORD_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_cycle,
    input  logic [1:0]        host_ctl,
    input  logic              host_rd,
    input  logic              host_sel,
    input  logic [ADDR_W-1:0] host_wdata,
    output logic [ADDR_W-1:0] host_rdata,
    output logic              dual_mode,
    output logic [ADDR_W-1:0] rd_ptr,
    output logic [ADDR_W-1:0] wr_ptr,
    output logic              rd_req,
    output logic              wr_req,
    output logic [ADDR_W-1:0] req_addr
);
    typedef struct packed {
        logic              mode;
        logic [ADDR_W-1:0] rdata;
        logic              rreq;
        logic              wreq;
        logic [ADDR_W-1:0] raddr;
    } state_t;

    state_t st_d, st_q;

    logic [NSLOT-1:0]  ld, inc;
    logic              cfg_wr, cfg_rd, ptr_rd, dreq_rd, dreq_wr;
    logic [ADDR_W-1:0] ptr_arr [NSLOT];

    hpu_decode u_dec (
        .cycle  (host_cycle),
        .ctl    (host_ctl),
        .rd     (host_rd),
        .sel    (host_sel),
        .dual   (st_q.mode),
        .ld     (ld),
        .inc    (inc),
        .cfg_wr (cfg_wr),
        .cfg_rd (cfg_rd),
        .ptr_rd (ptr_rd),
        .dreq_rd(dreq_rd),
        .dreq_wr(dreq_wr)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_ptr
        hpu_pointer #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_ptr (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (ld[g]),
            .inc     (inc[g]),
            .load_val(host_wdata),
            .ptr     (ptr_arr[g])
        );
    end

    always_comb begin
        st_d      = st_q;
        st_d.rreq = dreq_rd;
        st_d.wreq = dreq_wr;
        if (dreq_rd)      st_d.raddr = ptr_arr[SLOT_RD];
        else if (dreq_wr) st_d.raddr = ptr_arr[SLOT_WR];
        if (cfg_wr) st_d.mode  = host_wdata[0];
        if (cfg_rd) st_d.rdata = ADDR_W'(st_q.mode);
        if (ptr_rd) st_d.rdata = ptr_arr[SLOT_RD];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign host_rdata = st_q.rdata;
    assign dual_mode  = st_q.mode;
    assign rd_ptr     = ptr_arr[SLOT_RD];
    assign wr_ptr     = ptr_arr[SLOT_WR];
    assign rd_req     = st_q.rreq;
    assign wr_req     = st_q.wreq;
    assign req_addr   = st_q.raddr;

    // R9: never both requests
    a_r9_excl: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_req, wr_req}));
    // R9: read data cycle reports pre-increment read pointer
    a_r9_rd_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cycle && host_ctl[0] && host_rd) |=> rd_req && req_addr == $past(rd_ptr));
    // R9: write data cycle reports pre-increment write pointer
    a_r9_wr_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cycle && host_ctl[0] && !host_rd) |=> wr_req && req_addr == $past(wr_ptr));
    // R8: plain data cycle keeps pointers
    a_r8_no_move: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cycle && host_ctl == 2'b11) |=> $stable(rd_ptr) && $stable(wr_ptr));
    // R10: config write keeps pointers
    a_r10_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cycle && host_ctl == 2'b00) |=> $stable(rd_ptr) && $stable(wr_ptr));
    // R7: split-mode read increment leaves write pointer
    a_r7_split: assert property (@(posedge clk) disable iff (!rst_n)
        (dual_mode && host_cycle && host_ctl == 2'b01 && host_rd) |=> $stable(wr_ptr));
    // R12: idle cycle changes nothing
    a_r12_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !host_cycle |=> $stable(rd_ptr) && $stable(wr_ptr) && $stable(dual_mode)
                        && $stable(host_rdata) && !rd_req && !wr_req);
endmodule

// File: tb/test_hostptr_unit.sv
module test_hostptr_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_cycle = 1'b0;
    logic [1:0]  host_ctl = 2'b00;
    logic        host_rd = 1'b0;
    logic        host_sel = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata, rd_ptr, wr_ptr, req_addr;
    logic        dual_mode, rd_req, wr_req;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // expected model
    logic [31:0] e_rd = '0, e_wr = '0, e_rdata = '0, e_addr = '0;
    logic        e_mode = 1'b0, e_rreq = 1'b0, e_wreq = 1'b0;

    always #2.5 clk = ~clk;

    hostptr_unit i_hostptr_unit (
        .clk(clk), .rst_n(rst_n), .host_cycle(host_cycle), .host_ctl(host_ctl),
        .host_rd(host_rd), .host_sel(host_sel), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .dual_mode(dual_mode), .rd_ptr(rd_ptr),
        .wr_ptr(wr_ptr), .rd_req(rd_req), .wr_req(wr_req), .req_addr(req_addr)
    );

    function automatic logic [31:0] word_align(logic [31:0] v);
        return {v[31:2], 2'b00};
    endfunction

    function automatic logic [31:0] bump(logic [31:0] v);
        return v + 32'd4;
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(string tag);
        chk({tag, " rd_ptr"}, rd_ptr, e_rd);
        chk({tag, " wr_ptr"}, wr_ptr, e_wr);
        chk({tag, " mode"}, 32'(dual_mode), 32'(e_mode));
        chk({tag, " rdata"}, host_rdata, e_rdata);
        chk({tag, " R9 rd_req"}, 32'(rd_req), 32'(e_rreq));
        chk({tag, " R9 wr_req"}, 32'(wr_req), 32'(e_wreq));
        if (e_rreq || e_wreq) chk({tag, " R9 req_addr"}, req_addr, e_addr);
    endtask

    // one host cycle: drive at negedge, model, check at next negedge
    task automatic step(string tag, bit cyc, logic [1:0] ctl, bit rd, bit sel,
                        logic [31:0] wd);
        logic [31:0] n_rd, n_wr;
        host_cycle = cyc; host_ctl = ctl; host_rd = rd; host_sel = sel; host_wdata = wd;
        n_rd = e_rd; n_wr = e_wr;
        e_rreq = cyc && ctl[0] && rd;
        e_wreq = cyc && ctl[0] && !rd;
        if (e_rreq) e_addr = e_rd;
        if (e_wreq) e_addr = e_wr;
        if (cyc) begin
            case (ctl)
                2'b00: if (rd) e_rdata = {31'b0, e_mode};
                2'b10: if (rd) e_rdata = e_rd;
                       else if (!e_mode) begin n_rd = word_align(wd); n_wr = word_align(wd); end
                       else if (sel) n_rd = word_align(wd);
                       else n_wr = word_align(wd);
                2'b01: if (!e_mode) begin n_rd = bump(e_rd); n_wr = bump(e_wr); end
                       else if (rd) n_rd = bump(e_rd);
                       else n_wr = bump(e_wr);
                default: ;
            endcase
            if (ctl == 2'b00 && !rd) e_mode = wd[0];
        end
        e_rd = n_rd; e_wr = n_wr;
        @(negedge clk);
        check_all(tag);
    endtask

    initial begin
        @(negedge clk); @(negedge clk);
        check_all("R1 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1 after release");

        step("R3 shared load sel=1", 1, 2'b10, 0, 1, 32'h1234_567B);
        step("R5 readback", 1, 2'b10, 1, 0, 32'h0);
        step("R6 shared inc write", 1, 2'b01, 0, 0, 32'h0);
        step("R6 shared inc read", 1, 2'b01, 1, 0, 32'h0);
        step("R8 plain data", 1, 2'b11, 1, 0, 32'h0);
        step("R8 plain data wr", 1, 2'b11, 0, 0, 32'h0);
        step("R12 idle", 0, 2'b01, 1, 1, 32'hFFFF_FFFF);
        step("R2 cfg set split", 1, 2'b00, 0, 0, 32'h0000_0001);
        step("R2 cfg read", 1, 2'b00, 1, 0, 32'h0);
        step("R10 ptrs kept", 1, 2'b11, 0, 0, 32'h0);
        step("R4 split load rd", 1, 2'b10, 0, 1, 32'hFFFF_FFFE);
        step("R4 split load wr", 1, 2'b10, 0, 0, 32'h0000_1003);
        step("R7 split inc rd wrap R11", 1, 2'b01, 1, 0, 32'h0);
        step("R7 split inc wr", 1, 2'b01, 0, 0, 32'h0);
        step("R5 readback split", 1, 2'b10, 1, 0, 32'h0);
        step("R10 cfg clear", 1, 2'b00, 0, 0, 32'h0000_0000);
        step("R2 cfg read zero", 1, 2'b00, 1, 0, 32'h0);
        step("R3 shared load top", 1, 2'b10, 0, 0, 32'hFFFF_FFFF);
        step("R11 shared wrap", 1, 2'b01, 0, 0, 32'h0);

        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom();
            step("random", r[0] | r[1], r[3:2], r[4], r[5],
                 r[7:6] == 2'b00 ? (32'hFFFF_FFF0 | 32'($urandom_range(15))) : $urandom());
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        #500000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule